// File: doc/BRIEF.md
# Indexed and Read-Modify-Write Bus Sequencer

This block issues the cycle-by-cycle bus traffic of an 8-bit processor for two kinds of memory operation. The first is an indexed absolute read, where an 8-bit index is added to a 16-bit base. The second is a read-modify-write, which reads a byte, applies one of four one-step functions and stores the result. The caller presents a base address, an index, the address of the current opcode, an operation kind, a modify function and a compatibility mode, then pulses `start`. The sequencer puts out one bus cycle per clock until the operation ends. It then pulses `done` and presents the byte that was read or the byte that was written.

The compatibility mode sets where the extra dummy bus cycles fall. Devices mapped into memory can react to a read or a write, so the order and addresses of these cycles are part of the behaviour. In legacy mode the sequencer reproduces the older access pattern: a stray read inside the wrong page, and a write of the unchanged byte. In corrected mode it reproduces the newer pattern: a re-read of the opcode address, a re-read of a page-aligned base, and a second read in place of the first write. Every bus cycle shows on the `bus_*` ports, so a bench can keep a complete log of the cycles.

Top module: `idxrmw_bus_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted `start`, `bus_en`, `done` and `busy` are 0.
- R2: With `op_kind`=1 (read-modify-write) and `legacy_mode`=1, the sequence on the effective address EA=base+index is a read, then a write of the byte just read, then a write of the modified byte.
- R3: With `op_kind`=1 and `legacy_mode`=0, the sequence is a read of EA, a second read of EA, then a single write of the modified byte. The modified byte is taken from the second read.
- R4: `mod_fn` selects the modify function on 8 bits with wrap-around: 0 adds one, 1 subtracts one, 2 shifts left and fills bit 0 with zero, 3 shifts right and fills bit 7 with zero.
- R5: With `op_kind`=0 (indexed read) and `legacy_mode`=1, when base[7:0]+index carries out of bit 7, a dummy read of {base[15:8], (base[7:0]+index)[7:0]} comes before the read of EA.
- R6: With `op_kind`=0 and `legacy_mode`=0, when base[7:0] is not zero and the low-byte sum carries, a dummy read of `opcode_addr` comes before the read of EA.
- R7: With `op_kind`=0 and `legacy_mode`=0, when base[7:0] is zero, a dummy read of the base address comes before the read of EA. This holds even when the index is zero.
- R8: Any indexed read not covered by R5, R6 or R7 makes exactly one bus cycle, a read of EA. This includes a page-aligned base in legacy mode.
- R9: The first bus cycle comes in the clock after `start` is accepted, and one bus cycle follows on every clock with no gaps. `done` is high for exactly one clock, in the clock after the last bus cycle. During that clock `result` holds the byte read at EA (indexed read) or the byte written (read-modify-write).
- R10: A `start` seen while `busy` is high is ignored. The running sequence keeps its length and addresses, and no further bus cycle follows its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_kind | input | 1 | 0 indexed read, 1 read-modify-write |
| legacy_mode | input | 1 | 1 legacy access pattern, 0 corrected pattern |
| mod_fn | input | 2 | Modify function selector |
| base_addr | input | 16 | Base address |
| index_val | input | 8 | Index added to the base |
| opcode_addr | input | 16 | Address of the current opcode |
| bus_rdata | input | 8 | Read data, sampled at the end of a read cycle |
| bus_en | output | 1 | A bus cycle takes place this clock |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 16 | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-sequence pulse |
| result | output | 8 | Read byte or written byte, valid with done |

## Verification
The hardest case is the corrected-mode indexed read whose base low byte is zero while the index is also zero. It is the only case where a dummy cycle reads the very address that the real cycle then reads. The bench reaches it with a vector that uses a base of $3400 and an index of 0, and checks that the log holds two identical reads. A second hard case is the carry at the page edge with both low bytes at $FF, which leaves the invalid address one page below EA. The bench also holds `start` high across a whole read-modify-write, so that the busy-time starts actually reach the controller.

// File: rtl/idxrmw_pkg.sv
package idxrmw_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_PRE     = 3'd1,
    SQ_DATA    = 3'd2,
    SQ_RMW_RD  = 3'd3,
    SQ_RMW_MID = 3'd4,
    SQ_RMW_WR  = 3'd5
  } sq_state_e;

  typedef enum logic [1:0] {
    MF_INC = 2'd0,
    MF_DEC = 2'd1,
    MF_SHL = 2'd2,
    MF_SHR = 2'd3
  } mod_fn_e;

  localparam logic OP_IDX_READ = 1'b0;
  localparam logic OP_RMW      = 1'b1;

endpackage

// File: rtl/idxrmw_addr_gen.sv
module idxrmw_addr_gen #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] idx,
  input  logic [AW-1:0] opaddr,
  input  logic          legacy,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] uncarried,
  output logic          page_cross,
  output logic          base_aligned,
  output logic          need_pre,
  output logic [AW-1:0] pre_addr
);

  localparam int HW = AW - PW;

  function automatic logic [PW:0] f_low_sum(input logic [PW-1:0] b, input logic [PW-1:0] i);
    return {1'b0, b} + {1'b0, i};
  endfunction

  function automatic logic [AW-1:0] f_full_sum(input logic [AW-1:0] b, input logic [PW-1:0] i);
    return b + {{HW{1'b0}}, i};
  endfunction

  logic [PW:0] low_sum;

  always_comb begin
    low_sum      = f_low_sum(base[PW-1:0], idx);
    ea           = f_full_sum(base, idx);
    uncarried    = {base[AW-1:PW], low_sum[PW-1:0]};
    page_cross   = low_sum[PW];
    base_aligned = (base[PW-1:0] == '0);
    if (legacy) begin
      need_pre = page_cross;
      pre_addr = uncarried;
    end else begin
      need_pre = base_aligned | page_cross;
      pre_addr = base_aligned ? base : opaddr;
    end
  end

endmodule

// File: rtl/idxrmw_modify.sv
module idxrmw_modify #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val,
  input  logic [1:0]    fn,
  output logic [DW-1:0] res
);
  import idxrmw_pkg::*;

  function automatic logic [DW-1:0] f_modify(input logic [DW-1:0] v, input logic [1:0] f);
    case (mod_fn_e'(f))
      MF_INC:  return v + 1'b1;
      MF_DEC:  return v - 1'b1;
      MF_SHL:  return {v[DW-2:0], 1'b0};
      default: return {1'b0, v[DW-1:1]};
    endcase
  endfunction

  assign res = f_modify(val, fn);

endmodule

// File: rtl/idxrmw_ctrl.sv
module idxrmw_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  op_in,
  input  logic                  need_pre_in,
  output idxrmw_pkg::sq_state_e state_q,
  output logic                  accept,
  output logic                  done_q
);
  import idxrmw_pkg::*;

  sq_state_e state_d;
  logic      last_cycle;

  always_comb begin
    accept     = (state_q == SQ_IDLE) && start;
    last_cycle = (state_q == SQ_DATA) || (state_q == SQ_RMW_WR);
    state_d    = state_q;
    case (state_q)
      SQ_IDLE: if (start) begin
        if (op_in == OP_RMW) state_d = SQ_RMW_RD;
        else if (need_pre_in) state_d = SQ_PRE;
        else state_d = SQ_DATA;
      end
      SQ_PRE:     state_d = SQ_DATA;
      SQ_DATA:    state_d = SQ_IDLE;
      SQ_RMW_RD:  state_d = SQ_RMW_MID;
      SQ_RMW_MID: state_d = SQ_RMW_WR;
      SQ_RMW_WR:  state_d = SQ_IDLE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_cycle;
    end
  end

endmodule

// File: rtl/idxrmw_bus_seq.sv
module idxrmw_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_kind,
  input  logic          legacy_mode,
  input  logic [1:0]    mod_fn,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] index_val,
  input  logic [AW-1:0] opcode_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_en,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  import idxrmw_pkg::*;

  localparam int PW = DW;

  logic [AW-1:0] base_q, opaddr_q;
  logic [PW-1:0] idx_q;
  logic          legacy_q, op_q;
  logic [1:0]    fn_q;
  logic [DW-1:0] hold_q, result_q;

  sq_state_e     state_q;
  logic          accept, done_q, idle;

  logic [AW-1:0] v_base, v_opaddr;
  logic [PW-1:0] v_idx;
  logic          v_legacy;

  logic [AW-1:0] ea_w, uncarried_w, pre_addr_w;
  logic          page_cross_w, base_aligned_w, need_pre_w;
  logic [DW-1:0] mod_w;

  // event wires brought out for the checker
  logic          pre_cycle, final_wr;

  assign idle     = (state_q == SQ_IDLE);
  assign v_base   = idle ? base_addr   : base_q;
  assign v_idx    = idle ? index_val   : idx_q;
  assign v_opaddr = idle ? opcode_addr : opaddr_q;
  assign v_legacy = idle ? legacy_mode : legacy_q;

  idxrmw_addr_gen #(.AW(AW), .PW(PW)) u_agen (
    .base         (v_base),
    .idx          (v_idx),
    .opaddr       (v_opaddr),
    .legacy       (v_legacy),
    .ea           (ea_w),
    .uncarried    (uncarried_w),
    .page_cross   (page_cross_w),
    .base_aligned (base_aligned_w),
    .need_pre     (need_pre_w),
    .pre_addr     (pre_addr_w)
  );

  idxrmw_modify #(.DW(DW)) u_mod (
    .val (hold_q),
    .fn  (fn_q),
    .res (mod_w)
  );

  idxrmw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_in       (op_kind),
    .need_pre_in (need_pre_w),
    .state_q     (state_q),
    .accept      (accept),
    .done_q      (done_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      idx_q    <= '0;
      opaddr_q <= '0;
      legacy_q <= 1'b0;
      op_q     <= OP_IDX_READ;
      fn_q     <= '0;
    end else if (accept) begin
      base_q   <= base_addr;
      idx_q    <= index_val;
      opaddr_q <= opcode_addr;
      legacy_q <= legacy_mode;
      op_q     <= op_kind;
      fn_q     <= mod_fn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      result_q <= '0;
    end else begin
      case (state_q)
        SQ_RMW_RD:  hold_q <= bus_rdata;
        SQ_RMW_MID: if (!legacy_q) hold_q <= bus_rdata;
        SQ_DATA:    result_q <= bus_rdata;
        SQ_RMW_WR:  result_q <= mod_w;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_en    = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = ea_w;
    bus_wdata = '0;
    case (state_q)
      SQ_PRE:     bus_addr = pre_addr_w;
      SQ_DATA, SQ_RMW_RD: ;
      SQ_RMW_MID: if (legacy_q) begin
        bus_we    = 1'b1;
        bus_wdata = hold_q;
      end
      SQ_RMW_WR: begin
        bus_we    = 1'b1;
        bus_wdata = mod_w;
      end
      default: begin
        bus_en   = 1'b0;
        bus_addr = '0;
      end
    endcase
  end

  assign pre_cycle = (state_q == SQ_PRE);
  assign final_wr  = (state_q == SQ_RMW_WR);
  assign busy      = !idle;
  assign done      = done_q;
  assign result    = result_q;

endmodule

// File: rtl/idxrmw_bus_seq_chk.sv
module idxrmw_bus_seq_chk #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          busy,
  input logic          done,
  input logic          pre_cycle,
  input logic          final_wr,
  input logic          legacy_q,
  input logic          op_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] opaddr_q,
  input logic [AW-1:0] ea_w
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !done && !bus_en); // R1

  AST_LEGACY_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    final_wr && legacy_q |-> $past(bus_en) && $past(bus_we) && ($past(bus_addr) == bus_addr)); // R2

  AST_CORR_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && !legacy_q |-> $past(bus_en) && !$past(bus_we) && ($past(bus_addr) == bus_addr)); // R3

  AST_LEGACY_DUMMY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cycle && legacy_q |-> bus_addr[AW-1:PW] == base_q[AW-1:PW]); // R5

  AST_CORR_DUMMY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cycle && !legacy_q |-> (bus_addr == opaddr_q) || (bus_addr == base_q)); // R6

  AST_READ_ENDS_AT_EA: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_q |-> $past(bus_en) && !$past(bus_we) && ($past(bus_addr) == $past(ea_w))); // R8

  AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_en) && $past(busy)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind idxrmw_bus_seq idxrmw_bus_seq_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .busy      (busy),
  .done      (done),
  .pre_cycle (pre_cycle),
  .final_wr  (final_wr),
  .legacy_q  (legacy_q),
  .op_q      (op_q),
  .base_q    (base_q),
  .opaddr_q  (opaddr_q),
  .ea_w      (ea_w)
);

// File: tb/sim_idxrmw_bus_seq.sv
`timescale 1ns/1ps
module sim_idxrmw_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_kind = 1'b0;
  logic        legacy_mode = 1'b0;
  logic [1:0]  mod_fn = 2'd0;
  logic [15:0] base_addr = '0;
  logic [7:0]  index_val = '0;
  logic [15:0] opcode_addr = 16'hC0DE;
  logic [7:0]  bus_rdata;
  logic        bus_en, bus_we, busy, done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, result;

  always #4 clk = ~clk;

  idxrmw_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .legacy_mode(legacy_mode), .mod_fn(mod_fn), .base_addr(base_addr),
    .index_val(index_val), .opcode_addr(opcode_addr), .bus_rdata(bus_rdata),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [7:0] mem_of(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign bus_rdata = mem_of(bus_addr);

  int checks = 0;
  int fails = 0;
  int ncyc = 0;
  int n_log = 0;
  int done_t = -1;
  int log_t [0:15];
  logic [15:0] log_a [0:15];
  logic        log_w [0:15];
  logic [7:0]  log_d [0:15];
  logic [7:0]  res_at_done;

  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    if (bus_en && n_log < 16) begin
      log_t[n_log] <= ncyc + 1;
      log_a[n_log] <= bus_addr;
      log_w[n_log] <= bus_we;
      log_d[n_log] <= bus_wdata;
      n_log <= n_log + 1;
    end
    if (done) begin
      done_t      <= ncyc + 1;
      res_at_done <= result;
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  // expected model
  int          e_n;
  logic [15:0] e_a [0:3];
  logic        e_w [0:3];
  logic [7:0]  e_d [0:3];
  logic [7:0]  e_res;

  function automatic logic [7:0] modify_ref(input logic [7:0] v, input logic [1:0] f);
    logic [7:0] r;
    if (f == 2'd0) r = v + 8'd1;
    else if (f == 2'd1) r = v + 8'hFF;
    else if (f == 2'd2) r = v << 1;
    else r = v >> 1;
    return r;
  endfunction

  task automatic push(input logic [15:0] a, input logic w, input logic [7:0] d);
    e_a[e_n] = a; e_w[e_n] = w; e_d[e_n] = d; e_n++;
  endtask

  task automatic build_exp(input logic op, input logic leg, input logic [1:0] fn,
                           input logic [15:0] b, input logic [7:0] ix, output string tag);
    logic [8:0]  lo;
    logic [15:0] ea;
    logic [7:0]  v, m;
    e_n = 0;
    lo  = {1'b0, b[7:0]} + {1'b0, ix};
    ea  = b + {8'h00, ix};
    if (op) begin
      v = mem_of(ea);
      m = modify_ref(v, fn);
      push(ea, 1'b0, 8'h00);
      if (leg) begin push(ea, 1'b1, v); tag = "R2"; end
      else begin push(ea, 1'b0, 8'h00); tag = "R3"; end
      push(ea, 1'b1, m);
      e_res = m;
    end else begin
      tag = "R8";
      if (leg && lo[8]) begin push({b[15:8], lo[7:0]}, 1'b0, 8'h00); tag = "R5"; end
      else if (!leg && b[7:0] == 8'h00) begin push(b, 1'b0, 8'h00); tag = "R7"; end
      else if (!leg && lo[8]) begin push(opcode_addr, 1'b0, 8'h00); tag = "R6"; end
      push(ea, 1'b0, 8'h00);
      e_res = mem_of(ea);
    end
  endtask

  task automatic run_op(input logic op, input logic leg, input logic [1:0] fn,
                        input logic [15:0] b, input logic [7:0] ix, input int hold);
    int    t0;
    string tag;
    build_exp(op, leg, fn, b, ix, tag);
    @(negedge clk); #1;
    n_log = 0; done_t = -1; t0 = ncyc;
    op_kind = op; legacy_mode = leg; mod_fn = fn; base_addr = b; index_val = ix;
    start = 1'b1;
    for (int k = 0; k < hold; k++) begin @(negedge clk); #1; end
    start = 1'b0;
    for (int k = 0; k < 10 && done_t < 0; k++) begin @(negedge clk); #1; end
    for (int k = 0; k < 3; k++) begin @(negedge clk); #1; end
    chk(n_log == e_n, tag, "cycle count", n_log, e_n);
    for (int i = 0; i < e_n && i < n_log; i++) begin
      chk(log_a[i] == e_a[i], tag, "addr", log_a[i], e_a[i]);
      chk(log_w[i] == e_w[i], tag, "we", log_w[i], e_w[i]);
      if (e_w[i]) chk(log_d[i] == e_d[i], tag, "wdata", log_d[i], e_d[i]);
      chk(log_t[i] == t0 + 1 + i, "R9", "cycle slot", log_t[i], t0 + 1 + i);
    end
    chk(done_t == t0 + 1 + e_n, "R9", "done slot", done_t, t0 + 1 + e_n);
    chk(res_at_done == e_res, op ? "R4" : "R9", "result", res_at_done, e_res);
  endtask

  // {op, legacy, fn[1:0], base[15:0], index[7:0]}
  localparam int NV = 16;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 2'd0, 16'h12F0, 8'h20},  // R5 legacy carry
    {1'b0, 1'b1, 2'd0, 16'h12FF, 8'hFF},  // R5 edge
    {1'b0, 1'b1, 2'd0, 16'h1234, 8'h10},  // R8
    {1'b0, 1'b1, 2'd0, 16'h1200, 8'h05},  // R8 aligned legacy
    {1'b0, 1'b0, 2'd0, 16'h12F0, 8'h20},  // R6
    {1'b0, 1'b0, 2'd0, 16'h12FF, 8'hFF},  // R6 edge
    {1'b0, 1'b0, 2'd0, 16'h1200, 8'h05},  // R7
    {1'b0, 1'b0, 2'd0, 16'h3400, 8'h00},  // R7 zero index
    {1'b0, 1'b0, 2'd0, 16'h1234, 8'h10},  // R8
    {1'b1, 1'b1, 2'd0, 16'h0080, 8'h00},  // R2 inc
    {1'b1, 1'b1, 2'd2, 16'h20F0, 8'h20},  // R2 indexed shl
    {1'b1, 1'b0, 2'd0, 16'h0080, 8'h00},  // R3 inc
    {1'b1, 1'b0, 2'd1, 16'h005A, 8'h00},  // R4 dec wrap 00->FF
    {1'b1, 1'b1, 2'd0, 16'h00A5, 8'h00},  // R4 inc wrap FF->00
    {1'b1, 1'b0, 2'd2, 16'h00DA, 8'h00},  // R4 shl 80->00
    {1'b1, 1'b0, 2'd3, 16'h0025, 8'h00}   // R4 shr 7F->3F
  };

  initial begin
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(!bus_en && !done && !busy, "R1", "outputs in reset", {bus_en, done, busy}, 0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      chk(!bus_en && !done && !busy, "R1", "outputs after reset", {bus_en, done, busy}, 0);
    end

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][27], VEC[v][26], VEC[v][25:24], VEC[v][23:8], VEC[v][7:0], 1);

    // R10: start held high through a whole busy sequence
    run_op(1'b1, 1'b1, 2'd1, 16'h4444, 8'h01, 3);
    chk(n_log == 3, "R10", "no extra cycles after busy start", n_log, 3);
    run_op(1'b0, 1'b0, 2'd0, 16'h55F0, 8'h30, 2);
    chk(n_log == 2, "R10", "read kept its length", n_log, 2);

    finish_run();
  end

endmodule